// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block works out which processor units should take an inter-processor interrupt. Each of `NUM_UNITS` units presents an 8-bit physical identifier, an 8-bit logical identifier and a 4-bit destination-format code. A command arrives with its fields already split out: the shorthand (command bits 19:18), the destination mode (bit 11), the delivery mode (bits 10:8), the vector (bits 7:0) and the destination byte (high command word bits 31:24). The sender's unit index also comes with the command. One clock edge later the block presents a registered per-unit accept mask, together with the vector and the delivery mode.

For every delivery mode except lowest priority, the mask is simply the set of units the command addresses. For lowest-priority delivery the addressed set is first restricted to enabled units. A rotating pointer then keeps one of them: the search starts just after the unit chosen last time and wraps around. This is a fair spread of the load, not a true compare of unit priorities.

Top module: `ipi_dest_match`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `accept_valid` is 0 and `accept_mask` is all zero. The first lowest-priority search after reset starts at unit 0.
- R2: A command sampled with `cmd_valid` high appears on the outputs on the next clock edge. `accept_vector` and `accept_mode` equal the sampled `cmd_vector` and `cmd_dlv_mode`.
- R3: With shorthand 2'b00 and `cmd_dest_mode` = 0 (physical), unit i matches when `cmd_dest` is 8'hFF or equals its physical identifier.
- R4: With shorthand 2'b00, `cmd_dest_mode` = 1 (logical) and format code 4'hF (flat), unit i matches when its logical identifier ANDed with `cmd_dest` is nonzero.
- R5: With format code 4'h0 (cluster), unit i matches in logical mode when the upper nibble of its logical identifier equals the upper nibble of `cmd_dest` and the AND of the two lower nibbles is nonzero.
- R6: A format code other than 4'hF or 4'h0 makes the unit match no logical-mode command. Physical-mode matching of that unit is unaffected.
- R7: Shorthand 2'b01 selects only the sender, 2'b10 selects every unit and 2'b11 selects every unit except the sender. With any nonzero shorthand, `cmd_dest` and `cmd_dest_mode` have no effect.
- R8: For any delivery mode other than 3'b001, the mask is the full matched set, whatever `unit_enable` holds.
- R9: For delivery mode 3'b001 (lowest priority), exactly one bit is set. It is the first unit that is both matched and enabled, searching from the unit after the previous choice with wrap-around. That unit becomes the new previous choice.
- R10: If no matched unit is enabled for a lowest-priority command, the mask is zero and the previous choice is left unchanged.
- R11: In a cycle with `cmd_valid` low, the next `accept_valid` is 0, the mask is zero and the previous choice is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_shorthand | input | 2 | Shorthand field (command bits 19:18) |
| cmd_dest_mode | input | 1 | 0 physical, 1 logical (command bit 11) |
| cmd_dlv_mode | input | 3 | Delivery mode (command bits 10:8), 3'b001 = lowest priority |
| cmd_vector | input | 8 | Vector (command bits 7:0) |
| cmd_dest | input | 8 | Destination byte (high word bits 31:24) |
| sender_idx | input | $clog2(NUM_UNITS) | Index of the sending unit |
| unit_phys_id | input | 8*NUM_UNITS | Physical identifiers, unit i at [8i+7:8i] |
| unit_log_id | input | 8*NUM_UNITS | Logical identifiers, unit i at [8i+7:8i] |
| unit_fmt | input | 4*NUM_UNITS | Format codes, 4'hF flat, 4'h0 cluster |
| unit_enable | input | NUM_UNITS | Unit may take lowest-priority interrupts |
| accept_valid | output | 1 | Registered command-present flag |
| accept_mask | output | NUM_UNITS | Units that receive the interrupt |
| accept_vector | output | 8 | Registered vector |
| accept_mode | output | 3 | Registered delivery mode |

## Verification
Two things can act on the same command: the shorthand filter and the lowest-priority rotation. An all-except-self command in lowest-priority mode can arrive when the pointer's next slot is the sender itself. The bench sets this up by steering the pointer so that the next search would begin at the sender. It then expects the search to skip the sender and wrap to the lowest enabled other unit. A self-only lowest-priority command is checked the same way, where only the sender can be chosen.

// File: rtl/ipi_dm_pkg.sv
package ipi_dm_pkg;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  localparam logic [2:0] DLV_LOWEST  = 3'b001;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match #(
  parameter int UNIT_IDX = 0,
  parameter int IDX_W    = 2
) (
  input  ipi_dm_pkg::shorthand_e shorthand,
  input  logic                   logical,
  input  logic [7:0]             dest,
  input  logic [IDX_W-1:0]       sender,
  input  logic [7:0]             phys_id,
  input  logic [7:0]             log_id,
  input  logic [3:0]             fmt,
  output logic                   hit
);
  import ipi_dm_pkg::*;

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(UNIT_IDX);

  logic addressed;
  logic log_hit;

  // logical comparison depends on the unit's format code
  always_comb begin
    case (fmt)
      FMT_FLAT:    log_hit = |(log_id & dest);
      FMT_CLUSTER: log_hit = (log_id[7:4] == dest[7:4]) && |(log_id[3:0] & dest[3:0]);
      default:     log_hit = 1'b0;
    endcase
  end

  assign addressed = logical ? log_hit : ((dest == DEST_BCAST) || (dest == phys_id));

  always_comb begin
    case (shorthand)
      SH_NONE:   hit = addressed;
      SH_SELF:   hit = (sender == MY_IDX);
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = (sender != MY_IDX);
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_select.sv
module ipi_rr_select #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] prev,
  output logic [N-1:0]     pick,
  output logic [IDX_W-1:0] pick_idx,
  output logic             found
);

  // scan starts one past the previous choice and wraps once around
  always_comb begin
    pick     = '0;
    pick_idx = prev;
    found    = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = int'(prev) + off;
      if (idx >= N) idx = idx - N;
      if (!found && cand[IDX_W'(idx)]) begin
        found              = 1'b1;
        pick[IDX_W'(idx)]  = 1'b1;
        pick_idx           = IDX_W'(idx);
      end
    end
  end

endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int NUM_UNITS = 4,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_shorthand,
  input  logic                   cmd_dest_mode,
  input  logic [2:0]             cmd_dlv_mode,
  input  logic [7:0]             cmd_vector,
  input  logic [7:0]             cmd_dest,
  input  logic [IDX_W-1:0]       sender_idx,
  input  logic [8*NUM_UNITS-1:0] unit_phys_id,
  input  logic [8*NUM_UNITS-1:0] unit_log_id,
  input  logic [4*NUM_UNITS-1:0] unit_fmt,
  input  logic [NUM_UNITS-1:0]   unit_enable,
  output logic                   accept_valid,
  output logic [NUM_UNITS-1:0]   accept_mask,
  output logic [7:0]             accept_vector,
  output logic [2:0]             accept_mode
);
  import ipi_dm_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UNITS - 1);

  shorthand_e           sh;
  logic [NUM_UNITS-1:0] hits;
  logic [NUM_UNITS-1:0] cands;
  logic [NUM_UNITS-1:0] rr_pick;
  logic [IDX_W-1:0]     rr_idx;
  logic                 rr_found;
  logic [IDX_W-1:0]     prev_q;
  logic                 is_lowest;

  assign sh        = shorthand_e'(cmd_shorthand);
  assign is_lowest = (cmd_dlv_mode == DLV_LOWEST);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    ipi_unit_match #(
      .UNIT_IDX (g),
      .IDX_W    (IDX_W)
    ) u_match (
      .shorthand (sh),
      .logical   (cmd_dest_mode),
      .dest      (cmd_dest),
      .sender    (sender_idx),
      .phys_id   (unit_phys_id[8*g +: 8]),
      .log_id    (unit_log_id[8*g +: 8]),
      .fmt       (unit_fmt[4*g +: 4]),
      .hit       (hits[g])
    );
  end

  assign cands = hits & unit_enable;

  ipi_rr_select #(
    .N     (NUM_UNITS),
    .IDX_W (IDX_W)
  ) u_rr (
    .cand     (cands),
    .prev     (prev_q),
    .pick     (rr_pick),
    .pick_idx (rr_idx),
    .found    (rr_found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_valid  <= 1'b0;
      accept_mask   <= '0;
      accept_vector <= '0;
      accept_mode   <= '0;
      prev_q        <= LAST_IDX;
    end else begin
      accept_valid <= cmd_valid;
      if (cmd_valid) begin
        accept_mask   <= is_lowest ? rr_pick : hits;
        accept_vector <= cmd_vector;
        accept_mode   <= cmd_dlv_mode;
        if (is_lowest && rr_found) prev_q <= rr_idx;
      end else begin
        accept_mask <= '0;
      end
    end
  end

endmodule

// File: rtl/ipi_dest_match_chk.sv
module ipi_dest_match_chk #(
  parameter int NUM_UNITS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_shorthand,
  input logic [2:0]           cmd_dlv_mode,
  input logic [7:0]           cmd_vector,
  input logic [IDX_W-1:0]     sender_idx,
  input logic [NUM_UNITS-1:0] unit_enable,
  input logic                 accept_valid,
  input logic [NUM_UNITS-1:0] accept_mask,
  input logic [7:0]           accept_vector,
  input logic [2:0]           accept_mode
);

  logic [NUM_UNITS-1:0] sender_bit_q;
  logic [NUM_UNITS-1:0] enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sender_bit_q <= '0;
      enable_q     <= '0;
    end else begin
      sender_bit_q <= NUM_UNITS'(1) << sender_idx;
      enable_q     <= unit_enable;
    end
  end

  AST_IDLE_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    !accept_valid |-> (accept_mask == '0)); // R11

  AST_LOWEST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (accept_valid && accept_mode == 3'b001) |-> $onehot0(accept_mask)); // R9

  AST_LOWEST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (rst)
    (accept_valid && accept_mode == 3'b001) |-> ((accept_mask & ~enable_q) == '0)); // R9

  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_shorthand == 2'b01 && cmd_dlv_mode != 3'b001)
      |=> (accept_mask == sender_bit_q)); // R7

  AST_ALL_INCL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_shorthand == 2'b10 && cmd_dlv_mode != 3'b001)
      |=> (&accept_mask)); // R7

  AST_ALL_BUT_SELF: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_shorthand == 2'b11)
      |=> ((accept_mask & sender_bit_q) == '0)); // R7

  AST_VECTOR_FORWARD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (accept_valid && accept_vector == $past(cmd_vector)
                   && accept_mode == $past(cmd_dlv_mode))); // R2

endmodule

bind ipi_dest_match ipi_dest_match_chk #(
  .NUM_UNITS (NUM_UNITS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_shorthand (cmd_shorthand),
  .cmd_dlv_mode  (cmd_dlv_mode),
  .cmd_vector    (cmd_vector),
  .sender_idx    (sender_idx),
  .unit_enable   (unit_enable),
  .accept_valid  (accept_valid),
  .accept_mask   (accept_mask),
  .accept_vector (accept_vector),
  .accept_mode   (accept_mode)
);

// File: tb/test_ipi_dest_match.sv
module test_ipi_dest_match;

  localparam int N  = 4;
  localparam int IW = 2;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_shorthand = '0;
  logic          cmd_dest_mode = 1'b0;
  logic [2:0]    cmd_dlv_mode = '0;
  logic [7:0]    cmd_vector = '0;
  logic [7:0]    cmd_dest = '0;
  logic [IW-1:0] sender_idx = '0;
  logic [8*N-1:0] unit_phys_id;
  logic [8*N-1:0] unit_log_id;
  logic [4*N-1:0] unit_fmt;
  logic [N-1:0]   unit_enable = '1;
  logic           accept_valid;
  logic [N-1:0]   accept_mask;
  logic [7:0]     accept_vector;
  logic [2:0]     accept_mode;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // units: 0 phys 00 log 01 flat; 1 phys 01 log 02 flat;
  //        2 phys 05 log 12 cluster; 3 phys 07 log 13 cluster
  initial begin
    unit_phys_id = {8'h07, 8'h05, 8'h01, 8'h00};
    unit_log_id  = {8'h13, 8'h12, 8'h02, 8'h01};
    unit_fmt     = {4'h0, 4'h0, 4'hF, 4'hF};
  end

  ipi_dest_match #(.NUM_UNITS(N)) i_ipi_dest_match (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_shorthand (cmd_shorthand),
    .cmd_dest_mode (cmd_dest_mode),
    .cmd_dlv_mode  (cmd_dlv_mode),
    .cmd_vector    (cmd_vector),
    .cmd_dest      (cmd_dest),
    .sender_idx    (sender_idx),
    .unit_phys_id  (unit_phys_id),
    .unit_log_id   (unit_log_id),
    .unit_fmt      (unit_fmt),
    .unit_enable   (unit_enable),
    .accept_valid  (accept_valid),
    .accept_mask   (accept_mask),
    .accept_vector (accept_vector),
    .accept_mode   (accept_mode)
  );

  // {shorthand, dest_mode, dest, sender, expected mask}; fixed delivery
  localparam logic [16:0] VECS [NV] = '{
    {2'b00, 1'b0, 8'h05, 2'd0, 4'b0100},
    {2'b00, 1'b0, 8'hFF, 2'd0, 4'b1111},
    {2'b00, 1'b0, 8'h07, 2'd1, 4'b1000},
    {2'b00, 1'b0, 8'h03, 2'd0, 4'b0000},
    {2'b00, 1'b1, 8'h03, 2'd0, 4'b0011},
    {2'b00, 1'b1, 8'h12, 2'd0, 4'b1110},
    {2'b00, 1'b1, 8'h11, 2'd0, 4'b1001},
    {2'b01, 1'b0, 8'h00, 2'd2, 4'b0100},
    {2'b10, 1'b0, 8'h00, 2'd0, 4'b1111},
    {2'b11, 1'b1, 8'h00, 2'd1, 4'b1101},
    {2'b00, 1'b1, 8'h20, 2'd0, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [1:0] sh, input logic dm,
                      input logic [2:0] md, input logic [7:0] vec,
                      input logic [7:0] dst, input logic [IW-1:0] snd);
    cmd_valid     = v;
    cmd_shorthand = sh;
    cmd_dest_mode = dm;
    cmd_dlv_mode  = md;
    cmd_vector    = vec;
    cmd_dest      = dst;
    sender_idx    = snd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", 32'(accept_valid), 0);
    check("R1 mask in reset", 32'(accept_mask), 0);
    rst = 1'b0;
    send(1'b0, 2'b00, 1'b0, 3'b000, 8'h00, 8'h00, 2'd0);
    check("R1 valid after reset", 32'(accept_valid), 0);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] e;
      string tag;
      e = VECS[i];
      tag = (i < 4) ? "R3 physical" : (i < 7) ? "R4/R5 logical" : (i < 10) ? "R7 shorthand" : "R5 cluster";
      send(1'b1, e[16:15], e[14], 3'b000, 8'h40 + 8'(i), e[13:6], e[5:4]);
      check(tag, 32'(accept_mask), 32'(e[3:0]));
      check("R2 vector", 32'(accept_vector), 32'h40 + i);
      check("R2 valid", 32'(accept_valid), 1);
    end

    // idle cycle with lowest-priority fields: nothing out, pointer kept
    send(1'b0, 2'b00, 1'b0, 3'b001, 8'h11, 8'hFF, 2'd0);
    check("R11 idle valid", 32'(accept_valid), 0);
    check("R11 idle mask", 32'(accept_mask), 0);

    send(1'b1, 2'b00, 1'b0, 3'b001, 8'h50, 8'hFF, 2'd0);
    check("R1 first pick is unit 0", 32'(accept_mask), 32'b0001);
    check("R2 mode", 32'(accept_mode), 1);
    send(1'b1, 2'b00, 1'b0, 3'b001, 8'h51, 8'hFF, 2'd0);
    check("R9 rotate to 1", 32'(accept_mask), 32'b0010);
    send(1'b1, 2'b00, 1'b1, 3'b001, 8'h52, 8'h12, 2'd0);
    check("R9 logical pick 2", 32'(accept_mask), 32'b0100);
    send(1'b1, 2'b00, 1'b1, 3'b001, 8'h53, 8'h12, 2'd0);
    check("R9 logical pick 3", 32'(accept_mask), 32'b1000);
    send(1'b1, 2'b00, 1'b1, 3'b001, 8'h54, 8'h12, 2'd0);
    check("R9 wrap skip 0 pick 1", 32'(accept_mask), 32'b0010);

    unit_enable = 4'b0011;
    send(1'b1, 2'b00, 1'b1, 3'b001, 8'h55, 8'h12, 2'd0);
    check("R9 only enabled 1", 32'(accept_mask), 32'b0010);

    unit_enable = 4'b0000;
    send(1'b1, 2'b00, 1'b0, 3'b001, 8'h56, 8'hFF, 2'd0);
    check("R10 none enabled", 32'(accept_mask), 32'b0000);
    send(1'b1, 2'b00, 1'b0, 3'b000, 8'h57, 8'hFF, 2'd0);
    check("R8 fixed ignores enable", 32'(accept_mask), 32'b1111);

    unit_enable = 4'b1111;
    send(1'b1, 2'b00, 1'b0, 3'b001, 8'h58, 8'hFF, 2'd0);
    check("R10 pointer kept, pick 2", 32'(accept_mask), 32'b0100);

    // pointer now 2: next slot is the sender, all-but-self must skip it
    send(1'b1, 2'b11, 1'b0, 3'b001, 8'h59, 8'h00, 2'd3);
    check("R7 R9 all-but-self skips sender", 32'(accept_mask), 32'b0001);
    send(1'b1, 2'b01, 1'b0, 3'b001, 8'h5A, 8'hFF, 2'd2);
    check("R7 R9 self-only lowest", 32'(accept_mask), 32'b0100);

    unit_fmt = {4'h0, 4'h0, 4'h5, 4'hF};
    send(1'b1, 2'b00, 1'b1, 3'b000, 8'h5B, 8'h03, 2'd0);
    check("R6 bad format no logical hit", 32'(accept_mask), 32'b0001);
    send(1'b1, 2'b00, 1'b0, 3'b000, 8'h5C, 8'h01, 2'd0);
    check("R6 bad format physical still hits", 32'(accept_mask), 32'b0010);

    send(1'b0, 2'b00, 1'b0, 3'b000, 8'h00, 8'h00, 2'd0);
    check("R11 final idle", 32'(accept_mask), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule